// File: doc/BRIEF.md
# Conditional Move Execute Unit

This execute-stage unit completes a conditional register-to-register move. The decode stage has already fetched the source operand. It supplies the second opcode byte, the operand-size controls, a lock-prefix flag, the five arithmetic status flags, the current 64-bit destination value and the 64-bit source value.

The unit tests the condition selected by the low opcode nibble against the flags. It forms the new destination value and decides whether the register file is written. It raises an undefined-opcode fault for a locked or out-of-row opcode. The flags are returned untouched.

Results appear one clock after an accepted input, marked by `out_valid_o`. The output register is cleared by the active-low asynchronous reset.

Top module: `cmov_exec_unit`

## Requirements
- R1: The condition is chosen by `opcode_i[3:0]` with flags_i = {OF,SF,ZF,PF,CF} (bit 4 down to bit 0). The even codes are: 0 OF=1; 2 CF=1; 4 ZF=1; 6 CF=1 or ZF=1; 8 SF=1; A PF=1; C SF≠OF; E ZF=1 or SF≠OF. Each odd code is the inverse of the even code just below it.
- R2: In 64-bit operation (long_mode_i=1 and wide_i=1) a true condition writes the full source value.
- R3: In 32-bit operation in 64-bit mode (long_mode_i=1, wide_i=0, opsize_ovr_i=0) a true condition writes src[31:0] with bits 63:32 cleared.
- R4: In 32-bit operation in 64-bit mode a false condition still asserts wr_en_o. The result keeps dst[31:0] and clears bits 63:32.
- R5: In 16-bit operation (opsize_ovr_i=1, and not 64-bit operation) a true condition writes src[15:0] and keeps dst[63:16].
- R6: In 16-bit or 64-bit operation a false condition deasserts wr_en_o, and result_o equals dst_i.
- R7: lock_i=1 asserts ud_fault_o and deasserts wr_en_o, with result_o equal to dst_i.
- R8: An opcode byte whose high nibble is not 4 (outside 0x40 to 0x4F) asserts ud_fault_o and deasserts wr_en_o.
- R9: flags_o equals the flags_i value of the accepted input.
- R10: out_valid_o follows in_valid_i one cycle later, and is 0 during and just after reset. wr_en_o and ud_fault_o are 0 whenever out_valid_o is 0.
- R11: With long_mode_i=0, wide_i is ignored and the default size is 32 bits. A true condition then writes src[31:0] and keeps dst[63:32]. A false condition does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input operands valid |
| opcode_i | input | 8 | Second opcode byte |
| long_mode_i | input | 1 | 64-bit mode active |
| wide_i | input | 1 | Wide-operand prefix bit |
| opsize_ovr_i | input | 1 | Operand-size override prefix |
| lock_i | input | 1 | Lock prefix present |
| flags_i | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| dst_i | input | 64 | Current destination register value |
| src_i | input | 64 | Source operand value |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | New destination value |
| wr_en_o | output | 1 | Destination write enable |
| ud_fault_o | output | 1 | Undefined-opcode fault |
| flags_o | output | 5 | Status flags, unchanged |

## Verification
All sixteen condition codes are swept over all 32 flag combinations at 64-bit size. The flag-to-condition mapping and the inversion of odd codes are therefore separated code by code.

The source and destination use distinct byte patterns in every lane. This shows which lanes came from which operand at 16, 32 and 64 bits.

Each size is run with both a true and a false condition. This separates the 64-bit-mode 32-bit case, where a false condition still writes, from the 16-bit, 64-bit and legacy cases.

Locked and out-of-row opcodes are given with conditions that would otherwise be true. This shows that the fault overrides a write.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_32 = 2'd1,
    SZ_64 = 2'd2
  } opsize_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic pf_f;
    logic cf_f;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
  localparam logic [3:0] CMOV_ROW = 4'h4;
endpackage

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
#(
  parameter int unsigned CC_W = 4
) (
  input  logic [CC_W-1:0] cc_i,
  input  flags_t          flags_i,
  output logic            taken_o
);
  logic base;
  logic sf_ne_of;

  assign sf_ne_of = flags_i.sf_f ^ flags_i.of_f;

  always_comb begin
    unique case (cc_i[CC_W-1:1])
      3'd0: base = flags_i.of_f;
      3'd1: base = flags_i.cf_f;
      3'd2: base = flags_i.zf_f;
      3'd3: base = flags_i.cf_f | flags_i.zf_f;
      3'd4: base = flags_i.sf_f;
      3'd5: base = flags_i.pf_f;
      3'd6: base = sf_ne_of;
      default: base = flags_i.zf_f | sf_ne_of;
    endcase
  end

  // odd code negates its even partner
  assign taken_o = base ^ cc_i[0];
endmodule

// File: rtl/cmov_size_decode.sv
module cmov_size_decode
  import cmov_pkg::*;
(
  input  logic    long_mode_i,
  input  logic    wide_i,
  input  logic    opsize_ovr_i,
  output opsize_e size_o
);
  always_comb begin
    if (long_mode_i && wide_i) size_o = SZ_64;
    else if (opsize_ovr_i)     size_o = SZ_16;
    else                       size_o = SZ_32;
  end
endmodule

// File: rtl/cmov_merge.sv
module cmov_merge
  import cmov_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  opsize_e           size_i,
  input  logic              long_mode_i,
  input  logic              taken_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned QTR_W  = DATA_W / 4;

  always_comb begin
    result_o = dst_i;
    wr_en_o  = 1'b0;
    if (!fault_i) begin
      unique case (size_i)
        SZ_64: begin
          if (taken_i) begin
            result_o = src_i;
            wr_en_o  = 1'b1;
          end
        end
        SZ_32: begin
          if (long_mode_i) begin
            // 32-bit result zero-extends even when not taken
            wr_en_o                    = 1'b1;
            result_o[DATA_W-1:HALF_W]  = '0;
            result_o[HALF_W-1:0]       = taken_i ? src_i[HALF_W-1:0] : dst_i[HALF_W-1:0];
          end else if (taken_i) begin
            wr_en_o              = 1'b1;
            result_o[HALF_W-1:0] = src_i[HALF_W-1:0];
          end
        end
        default: begin
          if (taken_i) begin
            wr_en_o             = 1'b1;
            result_o[QTR_W-1:0] = src_i[QTR_W-1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cmov_out_reg.sv
module cmov_out_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned FLAG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              wr_en_i,
  input  logic              fault_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              fault_o,
  output logic [FLAG_W-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      wr_en_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i & wr_en_i;
      fault_o <= valid_i & fault_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (valid_i) begin
      result_o <= result_i;
      flags_o  <= flags_i;
    end
  end
endmodule

// File: rtl/cmov_exec_unit.sv
module cmov_exec_unit
  import cmov_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OPC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              long_mode_i,
  input  logic              wide_i,
  input  logic              opsize_ovr_i,
  input  logic              lock_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              ud_fault_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned CC_W = 4;

  flags_t            flags_s;
  opsize_e           size_s;
  logic              taken_s;
  logic              fault_s;
  logic              wr_en_s;
  logic [DATA_W-1:0] result_s;

  assign flags_s = flags_t'(flags_i);
  assign fault_s = lock_i | (opcode_i[OPC_W-1:CC_W] != CMOV_ROW);

  cmov_cond_eval #(.CC_W(CC_W)) i_cond (
    .cc_i    (opcode_i[CC_W-1:0]),
    .flags_i (flags_s),
    .taken_o (taken_s)
  );

  cmov_size_decode i_size (
    .long_mode_i  (long_mode_i),
    .wide_i       (wide_i),
    .opsize_ovr_i (opsize_ovr_i),
    .size_o       (size_s)
  );

  cmov_merge #(.DATA_W(DATA_W)) i_merge (
    .size_i      (size_s),
    .long_mode_i (long_mode_i),
    .taken_i     (taken_s),
    .fault_i     (fault_s),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .result_o    (result_s),
    .wr_en_o     (wr_en_s)
  );

  cmov_out_reg #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .result_i (result_s),
    .wr_en_i  (wr_en_s),
    .fault_i  (fault_s),
    .flags_i  (flags_i),
    .valid_o  (out_valid_o),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .fault_o  (ud_fault_o),
    .flags_o  (flags_o)
  );
endmodule

module cmov_exec_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned FLAG_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic              long_mode_i,
  input logic              wide_i,
  input logic              opsize_ovr_i,
  input logic              lock_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic              ud_fault_o,
  input logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  assert_valid_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !wr_en_o && !ud_fault_o);
  assert_lock_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && lock_i |=> ud_fault_o && !wr_en_o && result_o == $past(dst_i));
  assert_bad_opcode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && opcode_i[OPC_W-1:4] != 4'h4 |=> ud_fault_o && !wr_en_o);
  assert_flags_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> flags_o == $past(flags_i));
  assert_no_write_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !wr_en_o |-> result_o == $past(dst_i));
  assert_upper_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && long_mode_i && !wide_i && !opsize_ovr_i && !lock_i
      && opcode_i[OPC_W-1:4] == 4'h4
    |=> wr_en_o && result_o[DATA_W-1:HALF_W] == '0);
endmodule

bind cmov_exec_unit cmov_exec_unit_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W), .FLAG_W(cmov_pkg::FLAG_W)) i_chk (.*);

// File: tb/test_cmov_exec_unit.sv
module test_cmov_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h44;
  logic        long_mode = 1'b1, wide = 1'b0, ovr = 1'b0, lock = 1'b0;
  logic [4:0]  flags = 5'd0;
  logic [63:0] dst = '0, src = '0;
  logic        out_valid, wr_en, ud_fault;
  logic [63:0] result;
  logic [4:0]  flags_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [63:0] DST_PAT = 64'hD7D6_D5D4_D3D2_D1D0;
  localparam logic [63:0] SRC_PAT = 64'h5756_5554_5352_5150;

  always #10 clk = ~clk;

  cmov_exec_unit i_cmov_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .opcode_i(opcode),
    .long_mode_i(long_mode), .wide_i(wide), .opsize_ovr_i(ovr), .lock_i(lock),
    .flags_i(flags), .dst_i(dst), .src_i(src), .out_valid_o(out_valid),
    .result_o(result), .wr_en_o(wr_en), .ud_fault_o(ud_fault), .flags_o(flags_out)
  );

  // flags = {OF,SF,ZF,PF,CF}
  function automatic logic cond_ref(input logic [7:0] op, input logic [4:0] f);
    logic cf, pf, zf, sf, of;
    {of, sf, zf, pf, cf} = f;
    case (op[3:0])
      4'h0: return of;          4'h1: return !of;
      4'h2: return cf;          4'h3: return !cf;
      4'h4: return zf;          4'h5: return !zf;
      4'h6: return cf || zf;    4'h7: return !cf && !zf;
      4'h8: return sf;          4'h9: return !sf;
      4'hA: return pf;          4'hB: return !pf;
      4'hC: return sf != of;    4'hD: return sf == of;
      4'hE: return zf || (sf != of);
      default: return !zf && (sf == of);
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic lm, input logic w, input logic ov,
                       input logic lk, input logic [4:0] f, input logic [63:0] d,
                       input logic [63:0] s);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; long_mode = lm; wide = w; ovr = ov; lock = lk;
    flags = f; dst = d; src = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic exp_wr, input logic exp_ud,
                            input logic [63:0] exp_res);
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " wr_en"}, {63'd0, wr_en}, {63'd0, exp_wr});
    check({tag, " ud"}, {63'd0, ud_fault}, {63'd0, exp_ud});
    check({tag, " result"}, result, exp_res);
  endtask

  task automatic t_reset();
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset wr_en", {63'd0, wr_en}, 64'd0);
    check("R10 reset ud", {63'd0, ud_fault}, 64'd0);
  endtask

  task automatic t_cond_table();
    for (int op = 8'h40; op <= 8'h4F; op++) begin
      for (int f = 0; f < 32; f++) begin
        logic c;
        c = cond_ref(op[7:0], f[4:0]);
        apply(op[7:0], 1'b1, 1'b1, 1'b0, 1'b0, f[4:0], DST_PAT, SRC_PAT);
        check($sformatf("R1 op %h flags %b wr_en", op[7:0], f[4:0]), {63'd0, wr_en}, {63'd0, c});
      end
    end
  endtask

  task automatic t_wide();
    apply(8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00100, DST_PAT, SRC_PAT);
    expect_out("R2 64b taken", 1'b1, 1'b0, SRC_PAT);
    apply(8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00000, DST_PAT, SRC_PAT);
    expect_out("R6 64b not taken", 1'b0, 1'b0, DST_PAT);
  endtask

  task automatic t_dword_long();
    apply(8'h47, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000, DST_PAT, SRC_PAT);
    expect_out("R3 32b taken", 1'b1, 1'b0, {32'd0, SRC_PAT[31:0]});
    apply(8'h47, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00001, DST_PAT, SRC_PAT);
    expect_out("R4 32b not taken", 1'b1, 1'b0, {32'd0, DST_PAT[31:0]});
  endtask

  task automatic t_word();
    apply(8'h4F, 1'b1, 1'b0, 1'b1, 1'b0, 5'b11000, DST_PAT, SRC_PAT);
    expect_out("R5 16b taken", 1'b1, 1'b0, {DST_PAT[63:16], SRC_PAT[15:0]});
    apply(8'h4F, 1'b1, 1'b0, 1'b1, 1'b0, 5'b01000, DST_PAT, SRC_PAT);
    expect_out("R6 16b not taken", 1'b0, 1'b0, DST_PAT);
  endtask

  task automatic t_lock();
    apply(8'h42, 1'b1, 1'b1, 1'b0, 1'b1, 5'b00001, DST_PAT, SRC_PAT);
    expect_out("R7 lock 64b", 1'b0, 1'b1, DST_PAT);
    apply(8'h43, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00000, DST_PAT, SRC_PAT);
    expect_out("R7 lock 32b", 1'b0, 1'b1, DST_PAT);
  endtask

  task automatic t_bad_opcode();
    apply(8'h54, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00100, DST_PAT, SRC_PAT);
    expect_out("R8 opcode 54", 1'b0, 1'b1, DST_PAT);
    apply(8'h3F, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000, DST_PAT, SRC_PAT);
    expect_out("R8 opcode 3F", 1'b0, 1'b1, DST_PAT);
  endtask

  task automatic t_flags();
    apply(8'h46, 1'b1, 1'b1, 1'b0, 1'b0, 5'b10101, DST_PAT, SRC_PAT);
    check("R9 flags pattern a", {59'd0, flags_out}, {59'd0, 5'b10101});
    apply(8'h46, 1'b1, 1'b1, 1'b0, 1'b0, 5'b01010, DST_PAT, SRC_PAT);
    check("R9 flags pattern b", {59'd0, flags_out}, {59'd0, 5'b01010});
  endtask

  task automatic t_legacy();
    apply(8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00100, DST_PAT, SRC_PAT);
    expect_out("R11 legacy taken, wide ignored", 1'b1, 1'b0, {DST_PAT[63:32], SRC_PAT[31:0]});
    apply(8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00000, DST_PAT, SRC_PAT);
    expect_out("R11 legacy not taken", 1'b0, 1'b0, DST_PAT);
  endtask

  task automatic t_latency();
    apply(8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00100, DST_PAT, SRC_PAT);
    check("R10 valid after input", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R10 valid drops", {63'd0, out_valid}, 64'd0);
    check("R10 idle wr_en", {63'd0, wr_en}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cond_table();
    t_wide();
    t_dword_long();
    t_word();
    t_lock();
    t_bad_opcode();
    t_flags();
    t_legacy();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule